// File: doc/BRIEF.md
# Accumulator Address Select Unit

This unit forms the 4-bit addresses that index a 16-entry accumulator file. A 2-bit select picks one of four sources: the accumulator field of a 36-bit instruction word, the index field of that word, the low four bits of an 18-bit memory address, or an internal auto-incrementing counter. The unit drives two addresses. The primary address goes to the main read/write port. The secondary address goes to a second read port. The two are equal except under the memory-address source, where the secondary address comes from the index field instead.

The counter supports block walks through the accumulator file. It is cleared with a strobe. A step strobe forces both addresses to the counter's present value in that same cycle, and the counter advances by one at the clock edge that ends the cycle. Three combinational condition flags feed a branch unit. The first shows that the accumulator field is zero. The second shows that the index field or the indirect bit is nonzero. The third shows that the memory address falls inside the accumulator range.

Top module: `acc_addr_select`

## Requirements
- R1: With select 00 and no step strobe, both addresses equal instruction bits 26:23 (bit 0 is the least significant).
- R2: With select 01 and no step strobe, the primary address equals memory address bits 3:0 and the secondary address equals instruction bits 21:18.
- R3: With select 11 and no step strobe, both addresses equal instruction bits 21:18.
- R4: With select 10, both addresses equal the counter's current value.
- R5: While the step strobe is high, both addresses equal the counter value held before the edge, whatever the select. At that edge the counter increments by one, and it wraps from 15 to 0.
- R6: After reset the counter reads 0. The clear strobe sets it to 0 at the next edge and takes priority over a step in the same cycle. With neither strobe high, the counter holds its value.
- R7: The zero flag for the accumulator field is 1 exactly when instruction bits 26:23 are all 0. A single set bit in any of those four positions makes it 0.
- R8: The index/indirect flag is 1 when instruction bits 21:18 are nonzero or instruction bit 22 is set. Bits 35:27, 26:23 and 17:0 have no effect on it.
- R9: The memory-address-in-range flag is 1 for memory address values 0 to 15. It is 0 whenever any of bits 17:4 is set.
- R10: All three flags are combinational in the instruction and memory address inputs. They do not depend on the select, the strobes or the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 36 | Instruction word |
| mem_addr | input | 18 | Memory address register value |
| src_sel | input | 2 | Address source: 00 acc field, 01 memory address, 10 counter, 11 index field |
| cnt_clr | input | 1 | Clear the counter at the next edge |
| cnt_step | input | 1 | Use the counter this cycle, then increment it |
| acc_addr | output | 4 | Primary accumulator address |
| acc_addr_b | output | 4 | Secondary accumulator address |
| acf_zero | output | 1 | Accumulator field is zero |
| idx_ind_nz | output | 1 | Index field or indirect bit nonzero |
| ma_in_acc | output | 1 | Memory address lies in accumulator range |

## Verification
The addresses and all three flags depend combinationally on the inputs, so they are due in the same cycle the stimulus is applied. Counter strobes take effect one clock edge later. The bench drives inputs on the falling edge and samples every output one nanosecond later, comparing it with a behavioural model. The model's counter advances only at the rising edge that follows, so a strobe's effect is checked on the next cycle's sample and never on the cycle that issued it.

// File: rtl/acsel_pkg.sv
package acsel_pkg;
  typedef enum logic [1:0] {
    SRC_ACF = 2'b00,
    SRC_MA  = 2'b01,
    SRC_CNT = 2'b10,
    SRC_IDX = 2'b11
  } acsel_src_e;
endpackage

// File: rtl/acsel_fields.sv
module acsel_fields #(
  parameter int IW      = 36,
  parameter int MAW     = 18,
  parameter int AW      = 4,
  parameter int ACF_LSB = 23,
  parameter int IDX_LSB = 18,
  parameter int IND_BIT = 22
) (
  input  logic [IW-1:0]  instr,
  input  logic [MAW-1:0] mem_addr,
  output logic [AW-1:0]  acf,
  output logic [AW-1:0]  idxf,
  output logic [AW-1:0]  ma_lo,
  output logic           acf_zero,
  output logic           idx_ind_nz,
  output logic           ma_in_acc
);
  localparam int ACF_MSB = ACF_LSB + AW - 1;
  localparam int IDX_MSB = IDX_LSB + AW - 1;

  assign acf   = instr[ACF_MSB:ACF_LSB];
  assign idxf  = instr[IDX_MSB:IDX_LSB];
  assign ma_lo = mem_addr[AW-1:0];

  assign acf_zero   = ~|acf;
  assign idx_ind_nz = (|idxf) | instr[IND_BIT];
  assign ma_in_acc  = ~|mem_addr[MAW-1:AW];
endmodule

// File: rtl/acsel_counter.sv
module acsel_counter #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] cnt_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/acsel_mux.sv
module acsel_mux
  import acsel_pkg::*;
#(
  parameter int AW = 4
) (
  input  acsel_src_e    src,
  input  logic          step,
  input  logic [AW-1:0] acf,
  input  logic [AW-1:0] idxf,
  input  logic [AW-1:0] ma_lo,
  input  logic [AW-1:0] cnt,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b
);
  always_comb begin
    if (step) begin
      addr_a = cnt;
      addr_b = cnt;
    end else begin
      unique case (src)
        SRC_ACF: begin addr_a = acf;   addr_b = acf;  end
        SRC_MA:  begin addr_a = ma_lo; addr_b = idxf; end
        SRC_CNT: begin addr_a = cnt;   addr_b = cnt;  end
        SRC_IDX: begin addr_a = idxf;  addr_b = idxf; end
        default: begin addr_a = acf;   addr_b = acf;  end
      endcase
    end
  end
endmodule

// File: rtl/acc_addr_select.sv
module acc_addr_select
  import acsel_pkg::*;
#(
  parameter int IW      = 36,
  parameter int MAW     = 18,
  parameter int NACC    = 16,
  parameter int ACF_LSB = 23,
  parameter int IDX_LSB = 18,
  parameter int IND_BIT = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IW-1:0]            instr,
  input  logic [MAW-1:0]           mem_addr,
  input  logic [1:0]               src_sel,
  input  logic                     cnt_clr,
  input  logic                     cnt_step,
  output logic [$clog2(NACC)-1:0]  acc_addr,
  output logic [$clog2(NACC)-1:0]  acc_addr_b,
  output logic                     acf_zero,
  output logic                     idx_ind_nz,
  output logic                     ma_in_acc
);
  localparam int AW = $clog2(NACC);

  logic [AW-1:0] acf, idxf, ma_lo, cnt_q;
  acsel_src_e    src;

  assign src = acsel_src_e'(src_sel);

  acsel_fields #(
    .IW(IW), .MAW(MAW), .AW(AW),
    .ACF_LSB(ACF_LSB), .IDX_LSB(IDX_LSB), .IND_BIT(IND_BIT)
  ) u_fields (
    .instr(instr), .mem_addr(mem_addr),
    .acf(acf), .idxf(idxf), .ma_lo(ma_lo),
    .acf_zero(acf_zero), .idx_ind_nz(idx_ind_nz), .ma_in_acc(ma_in_acc)
  );

  acsel_counter #(.AW(AW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(cnt_step), .cnt_q(cnt_q)
  );

  acsel_mux #(.AW(AW)) u_mux (
    .src(src), .step(cnt_step), .acf(acf), .idxf(idxf), .ma_lo(ma_lo),
    .cnt(cnt_q), .addr_a(acc_addr), .addr_b(acc_addr_b)
  );
endmodule

// File: rtl/acsel_checker.sv
module acsel_checker #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    src_sel,
  input logic          cnt_clr,
  input logic          cnt_step,
  input logic [AW-1:0] cnt_q,
  input logic [AW-1:0] acc_addr,
  input logic [AW-1:0] acc_addr_b,
  input logic          acf_zero
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // R5: a step without clear advances the counter by one, wrapping
  a_r5_step_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && !cnt_clr) |=> (cnt_q == $past(cnt_q) + ONE));

  // R5: the strobe routes the counter to both addresses
  a_r5_step_route: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |-> (acc_addr == cnt_q && acc_addr_b == cnt_q));

  // R6: clear wins and zeroes the counter
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0));

  // R6: no strobe, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !cnt_step) |=> $stable(cnt_q));

  // R4: counter source
  a_r4_cnt_src: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b10) |-> (acc_addr == cnt_q));

  // R7: zero flag agrees with the address picked from the acc field
  a_r7_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && !cnt_step) |-> (acf_zero == (acc_addr == '0)));
endmodule

bind acc_addr_select acsel_checker #(.AW(AW)) u_acsel_checker (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cnt_clr(cnt_clr),
  .cnt_step(cnt_step), .cnt_q(cnt_q), .acc_addr(acc_addr),
  .acc_addr_b(acc_addr_b), .acf_zero(acf_zero)
);

// File: tb/acc_addr_select_bench.sv
module acc_addr_select_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] instr = '0;
  logic [17:0] mem_addr = '0;
  logic [1:0]  src_sel = 2'b00;
  logic        cnt_clr = 1'b0;
  logic        cnt_step = 1'b0;
  logic [3:0]  acc_addr, acc_addr_b;
  logic        acf_zero, idx_ind_nz, ma_in_acc;

  int nchk = 0;
  int nfail = 0;
  int mcnt = 0;   // model counter
  bit done = 0;

  always #2 clk = ~clk;

  acc_addr_select u_acc_addr_select (
    .clk(clk), .rst_n(rst_n), .instr(instr), .mem_addr(mem_addr),
    .src_sel(src_sel), .cnt_clr(cnt_clr), .cnt_step(cnt_step),
    .acc_addr(acc_addr), .acc_addr_b(acc_addr_b), .acf_zero(acf_zero),
    .idx_ind_nz(idx_ind_nz), .ma_in_acc(ma_in_acc)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [35:0] ins, input logic [17:0] m,
                       input logic [1:0] s, input bit st, input bit cl,
                       input string tag_override);
    int acf, idx, ind, ea, eb;
    string tag;
    instr = ins; mem_addr = m; src_sel = s; cnt_step = st; cnt_clr = cl;
    #1;
    acf = int'(ins[26:23]);
    idx = int'(ins[21:18]);
    ind = int'(ins[22]);
    if (st) begin ea = mcnt; eb = mcnt; tag = "R5"; end
    else case (s)
      2'b00: begin ea = acf; eb = acf; tag = "R1"; end
      2'b01: begin ea = int'(m[3:0]); eb = idx; tag = "R2"; end
      2'b10: begin ea = mcnt; eb = mcnt; tag = "R4"; end
      default: begin ea = idx; eb = idx; tag = "R3"; end
    endcase
    if (tag_override != "") tag = tag_override;
    chk(tag, "acc_addr", int'(acc_addr), ea);
    chk(tag, "acc_addr_b", int'(acc_addr_b), eb);
    chk("R7/R10", "acf_zero", int'(acf_zero), (acf == 0) ? 1 : 0);
    chk("R8/R10", "idx_ind_nz", int'(idx_ind_nz), (idx != 0 || ind != 0) ? 1 : 0);
    chk("R9/R10", "ma_in_acc", int'(ma_in_acc), (m < 18'd16) ? 1 : 0);
    @(posedge clk);
    if (rst_n) begin
      if (cl) mcnt = 0;
      else if (st) mcnt = (mcnt + 1) % 16;
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state of the counter
    apply('0, '0, 2'b10, 0, 0, "R6");
    // R1 / R7: walk acc field, single bits and all-ones
    apply('0, '0, 2'b00, 0, 0, "");
    for (int b = 23; b <= 26; b++) apply(36'd1 << b, '0, 2'b00, 0, 0, "");
    apply(36'hF << 23, 18'h3, 2'b00, 0, 0, "");
    // R8: other fields must not set the flag
    apply(36'hFF8000000 | 36'h3FFFF | (36'hF << 23), '0, 2'b00, 0, 0, "R8");
    apply(36'd1 << 22, '0, 2'b00, 0, 0, "");
    for (int b = 18; b <= 21; b++) apply(36'd1 << b, '0, 2'b11, 0, 0, "");
    // R2: memory address source
    apply((36'd9 << 23) | (36'd6 << 18), 18'd13, 2'b01, 0, 0, "");
    for (int v = 0; v <= 16; v++) apply('0, 18'(v), 2'b01, 0, 0, "");
    for (int b = 4; b < 18; b++) apply('0, (18'd1 << b) | 18'd5, 2'b01, 0, 0, "R9");
    apply(36'd5 << 18, 18'h3FFFF, 2'b11, 0, 0, "");
    // R5: step through and past the wrap, with various selects
    for (int k = 0; k < 18; k++) apply(36'd7 << 23, 18'd2, 2'(k % 4), 1, 0, "");
    apply('0, '0, 2'b10, 0, 0, "R5");
    // R6: hold, clear, clear beats step
    apply('0, '0, 2'b10, 0, 0, "R6");
    apply('0, '0, 2'b00, 0, 1, "");
    apply('0, '0, 2'b10, 0, 0, "R6");
    apply('0, '0, 2'b10, 1, 0, "");
    apply('0, '0, 2'b10, 1, 1, "R5");
    apply('0, '0, 2'b10, 0, 0, "R6");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule